// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Frame Filtering

This block turns an asynchronous serial line into received characters of five to nine data bits. An external rate generator supplies one `baud_tick` pulse per sample period. In normal speed the receiver takes sixteen samples per bit. When `dbl_speed` is set it takes eight samples per bit, which doubles the bit rate for the same tick rate. Each bit is decided by a majority vote over the three samples around mid-bit. A start bit counts only if that vote reads low.

A finished character goes into a holding register. With nine-bit characters, the top bit is held in a separate output next to the low eight bits. The block keeps a completion flag that a read strobe clears, a frame-error flag and an overrun flag. Its interrupt request is gated by a local enable and a global enable.

In multiprocessor mode the receiver keeps only address frames. An address frame carries a 1 in its marker bit, and every other frame is discarded without touching any register. Clearing the receiver enable aborts any frame in progress and empties the holding register and its flags.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_data`, `rx_bit8`, `rx_done`, `frame_err`, `overrun` and `rx_irq` are all 0.
- R2: `char_size` selects the number of data bits: 000=5, 001=6, 010=7, 011=8, 111=9, and any other code means 8. Data is received LSB first, and bits of `rx_data` above the character size read 0.
- R3: For 9-bit characters, the ninth data bit appears on `rx_bit8`. For shorter characters `rx_bit8` is 0.
- R4: A bit lasts 16 `baud_tick` periods with `dbl_speed`=0 and 8 periods with `dbl_speed`=1. The falling-edge tick counts as sample 0 of the start bit.
- R5: Each bit value is the majority of samples 7, 8 and 9 (or 3, 4 and 5 at double speed). A single wrong sample among them does not change the bit, but two wrong samples do.
- R6: A low level that reads high in the mid-bit vote of the start bit is discarded, and no character is produced.
- R7: A stop bit voted 0 sets `frame_err`, and the character is still stored. A good stop bit stores `frame_err`=0.
- R8: If a character completes while `rx_done` is still 1, `overrun` is set and `rx_data` keeps the old value. The next stored character clears `overrun`.
- R9: A one-cycle `rd_strobe` clears `rx_done` on the next clock.
- R10: With `mp_mode`=1, a marker bit follows the data bits: it is a separate bit for sizes 5 to 8, and it is the ninth data bit itself for size 9. A frame whose marker is 0 leaves every output unchanged. A frame whose marker is 1 is stored like a normal frame, with the marker excluded from `rx_data`.
- R11: While `rx_en`=0, the holding register, `rx_bit8` and all flags read 0 one clock later, and no frame is received.
- R12: `rx_irq` is 1 exactly when `rx_int_en`, `glob_int_en` and `rx_done` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One pulse per sample period |
| rx_en | input | 1 | Receiver enable; 0 flushes the holding register and flags |
| dbl_speed | input | 1 | 1 selects 8 samples per bit instead of 16 |
| mp_mode | input | 1 | Keep only frames whose marker bit is 1 |
| char_size | input | 3 | Character size code |
| rx_int_en | input | 1 | Local interrupt enable |
| glob_int_en | input | 1 | Global interrupt enable |
| rd_strobe | input | 1 | Read of the holding register; clears `rx_done` |
| rx_data | output | 8 | Low eight bits of the received character |
| rx_bit8 | output | 1 | Ninth data bit |
| rx_done | output | 1 | Unread character present |
| frame_err | output | 1 | Stop bit of the stored character was 0 |
| overrun | output | 1 | A character was lost because the register was unread |
| rx_irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench sends random characters of every size at both sample rates. Values with differing high bits show whether the size mask and the ninth-bit output are right. Directed frames with one or two corrupted samples at mid-bit show whether a majority vote is used rather than a single sample. A start pulse that ends too soon shows that the start bit is checked before a character is framed. In multiprocessor mode, frames with the marker at 0 and at 1 are sent for both short and 9-bit sizes. Together with back-to-back frames without a read and a disable in the middle of activity, these separate filtering from overrun and from flushing.

// File: rtl/uart_rx_pkg.sv
// Shared constants, state type and size decode for the serial receiver.
// Assumes at most nine data bits per character.
package uart_rx_pkg;
    localparam int DATA_W = 8;
    localparam int FULL_W = DATA_W + 1;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    // Map the 3-bit size code to a data-bit count (5..9, 8 for unused codes).
    function automatic logic [3:0] size_bits(input logic [2:0] code);
        case (code)
            3'b000:  size_bits = 4'd5;
            3'b001:  size_bits = 4'd6;
            3'b010:  size_bits = 4'd7;
            3'b111:  size_bits = 4'd9;
            default: size_bits = 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/uart_rx_vote.sv
// Line synchronizer and three-sample majority voter.
// Assumes the framer supplies the sample counter and the mid-bit index;
// the vote output is valid in the tick where cnt equals mid+1.
module uart_rx_vote #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mid,
    output logic             line,
    output logic             vote
);
    logic       sync_a;
    logic       samp_lo;
    logic       samp_mid;
    logic [CNT_W-1:0] mid_m1;

    assign mid_m1 = mid - 1'b1;

    // Two-stage synchronizer on the asynchronous line; resets to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            line   <= 1'b1;
        end else begin
            sync_a <= rxd_in;
            line   <= sync_a;
        end
    end

    // Capture the two samples that precede the deciding one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_lo  <= 1'b1;
            samp_mid <= 1'b1;
        end else if (tick) begin
            if (cnt == mid_m1) samp_lo  <= line;
            if (cnt == mid)    samp_mid <= line;
        end
    end

    // Majority of the two stored samples and the current one.
    always_comb begin
        vote = (samp_lo & samp_mid) | (samp_lo & line) | (samp_mid & line);
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Frame sequencer: start detection, data/marker shifting and stop check.
// Assumes baud_tick is a single-cycle pulse per sample period and that the
// configuration stays constant while a frame is in progress.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              line,
    input  logic              vote,
    input  logic              dbl,
    input  logic              mp,
    input  logic [2:0]        size_code,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  mid,
    output logic              done,
    output logic              stop_bad,
    output logic              marker,
    output logic              nine,
    output logic [FULL_W-1:0] data_out
);
    localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OVS / 2);
    localparam logic [CNT_W-1:0] MID_D  = CNT_W'(OVS / 4);
    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(OVS / 2 - 1);

    rx_state_t         state;
    logic [3:0]        bit_idx;
    logic [FULL_W-1:0] sh;
    logic [3:0]        nb;
    logic [3:0]        n_total;
    logic [3:0]        mk_idx;
    logic [CNT_W-1:0]  last;
    logic [CNT_W-1:0]  mid_p1;
    logic [FULL_W-1:0] aligned;
    logic [FULL_W-1:0] mask;

    // Derive bit counts and sample positions from the configuration.
    always_comb begin
        nb      = size_bits(size_code);
        nine    = (nb == 4'(FULL_W));
        n_total = nb + {3'b000, (mp && !nine)};
        mid     = dbl ? MID_D : MID_N;
        last    = dbl ? LAST_D : LAST_N;
        mid_p1  = mid + 1'b1;
        aligned = sh >> (4'(FULL_W) - n_total);
        mask    = (FULL_W'(1) << nb) - FULL_W'(1);
        mk_idx  = nine ? nb - 4'd1 : nb;
        marker  = aligned[mk_idx];
        data_out = aligned & mask;
    end

    // Sequence one frame per start bit, one step per sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            done     <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else if (tick) begin
                if (state == RX_IDLE) begin
                    if (!line) begin
                        state <= RX_START;
                        cnt   <= CNT_W'(1);
                    end
                end else begin
                    if (cnt == mid_p1) begin
                        case (state)
                            RX_START: if (vote) state <= RX_IDLE;
                            RX_DATA: begin
                                sh      <= {vote, sh[FULL_W-1:1]};
                                bit_idx <= bit_idx + 4'd1;
                            end
                            RX_STOP: begin
                                done     <= 1'b1;
                                stop_bad <= !vote;
                                state    <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == last) begin
                        cnt <= '0;
                        if (state == RX_START) begin
                            state   <= RX_DATA;
                            bit_idx <= '0;
                        end else if (state == RX_DATA && bit_idx == n_total) begin
                            state <= RX_STOP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_hold.sv
// Holding register with completion, frame-error and overrun flags, the
// address filter and the interrupt gate. Assumes done is a one-cycle pulse.
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              done,
    input  logic              stop_bad,
    input  logic              marker,
    input  logic              nine,
    input  logic              mp,
    input  logic [FULL_W-1:0] data_in,
    input  logic              rd,
    input  logic              ie,
    input  logic              gie,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              frame_err,
    output logic              overrun,
    output logic              irq
);
    logic accept;

    // A finished frame is kept unless the address filter rejects it.
    always_comb begin
        accept = done && !(mp && !marker);
        irq    = ie && gie && rx_done;
    end

    // Load, overrun, read-clear and flush of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            rx_data   <= '0;
            rx_bit8   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else if (accept) begin
            if (rx_done && !rd) begin
                overrun <= 1'b1;
            end else begin
                rx_data   <= data_in[DATA_W-1:0];
                rx_bit8   <= nine && data_in[FULL_W-1];
                rx_done   <= 1'b1;
                frame_err <= stop_bad;
                overrun   <= 1'b0;
            end
        end else if (rd) begin
            rx_done <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_addr_rx.sv
// Top level of the serial receiver: voter, frame sequencer and holding
// register. Assumes an external source of one baud_tick per sample period.
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              rx_en,
    input  logic              dbl_speed,
    input  logic              mp_mode,
    input  logic [2:0]        char_size,
    input  logic              rx_int_en,
    input  logic              glob_int_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              frame_err,
    output logic              overrun,
    output logic              rx_irq
);
    localparam int CNT_W = $clog2(OVS);

    logic [CNT_W-1:0]  smp_cnt;
    logic [CNT_W-1:0]  smp_mid;
    logic              line_s;
    logic              bit_vote;
    logic              frame_done;
    logic              stop_bad;
    logic              frm_marker;
    logic              frm_nine;
    logic [FULL_W-1:0] frm_data;

    uart_rx_vote #(.CNT_W(CNT_W)) u_vote (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_in(rxd),
        .cnt(smp_cnt), .mid(smp_mid), .line(line_s), .vote(bit_vote)
    );

    uart_rx_frame #(.OVS(OVS), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(baud_tick),
        .line(line_s), .vote(bit_vote), .dbl(dbl_speed), .mp(mp_mode),
        .size_code(char_size), .cnt(smp_cnt), .mid(smp_mid),
        .done(frame_done), .stop_bad(stop_bad), .marker(frm_marker),
        .nine(frm_nine), .data_out(frm_data)
    );

    uart_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .done(frame_done),
        .stop_bad(stop_bad), .marker(frm_marker), .nine(frm_nine),
        .mp(mp_mode), .data_in(frm_data), .rd(rd_strobe),
        .ie(rx_int_en), .gie(glob_int_en), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .rx_done(rx_done), .frame_err(frame_err),
        .overrun(overrun), .irq(rx_irq)
    );
endmodule

// File: rtl/uart_rx_checker.sv
// Temporal properties of the receiver, bound onto the top module.
module uart_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_strobe,
    input logic       mp_mode,
    input logic       frame_done,
    input logic       frm_marker,
    input logic       rx_done,
    input logic       frame_err,
    input logic       overrun,
    input logic       rx_irq,
    input logic [7:0] rx_data
);
    assert_flush_on_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_done && !frame_err && !overrun && rx_data == 8'h00));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !rx_done);

    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_done));

    assert_done_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frame_done));

    assert_filter_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_en && mp_mode && !frm_marker && !rd_strobe) |=>
        ($stable(rx_done) && $stable(rx_data) && $stable(overrun) && $stable(frame_err)));

    assert_irq_needs_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_done);
endmodule

bind uart_addr_rx uart_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .mp_mode(mp_mode), .frame_done(frame_done), .frm_marker(frm_marker),
    .rx_done(rx_done), .frame_err(frame_err), .overrun(overrun),
    .rx_irq(rx_irq), .rx_data(rx_data)
);

// File: tb/tb_uart_addr_rx.sv
`timescale 1ns/1ps
module tb_uart_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       dbl_speed = 1'b0;
    logic       mp_mode = 1'b0;
    logic [2:0] char_size = 3'b011;
    logic       rx_int_en = 1'b0;
    logic       glob_int_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_done, frame_err, overrun, rx_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .rx_en(rx_en), .dbl_speed(dbl_speed), .mp_mode(mp_mode),
        .char_size(char_size), .rx_int_en(rx_int_en),
        .glob_int_en(glob_int_en), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_done(rx_done),
        .frame_err(frame_err), .overrun(overrun), .rx_irq(rx_irq)
    );

    function automatic logic [2:0] code_of(input int nb);
        case (nb)
            5: code_of = 3'b000;
            6: code_of = 3'b001;
            7: code_of = 3'b010;
            9: code_of = 3'b111;
            default: code_of = 3'b011;
        endcase
    endfunction

    function automatic logic [7:0] exp_low(input int nb, input logic [8:0] d);
        logic [8:0] m;
        m = (9'd1 << nb) - 9'd1;
        exp_low = 8'(d & m);
    endfunction

    function automatic logic exp_b8(input int nb, input logic [8:0] d);
        exp_b8 = (nb == 9) ? d[8] : 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One sample period: line value held four clocks, tick in the last one.
    task automatic tick1(input logic v);
        rxd = v;
        baud_tick = 1'b0;
        repeat (3) @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic send_bit(input logic v, input logic [15:0] gmask);
        int spb;
        spb = dbl_speed ? 8 : 16;
        for (int i = 0; i < spb; i++) tick1(gmask[i] ? ~v : v);
    endtask

    // Start, data LSB first, optional marker, stop, two idle samples.
    // gbit selects the data bit that receives the glitch mask.
    task automatic send_frame(input int nb, input logic [8:0] d, input bit use_mk,
                              input logic mk, input logic stopv,
                              input int gbit, input logic [15:0] gmask);
        send_bit(1'b0, 16'h0);
        for (int i = 0; i < nb; i++) send_bit(d[i], (i == gbit) ? gmask : 16'h0);
        if (use_mk) send_bit(mk, 16'h0);
        send_bit(stopv, 16'h0);
        tick1(1'b1);
        tick1(1'b1);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 rx_data", 32'(rx_data), 0);
        check("R1 flags", {rx_bit8, rx_done, frame_err, overrun, rx_irq}, 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R4: 8-bit frame at normal speed
        send_frame(8, 9'h0A5, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R2 data 8-bit", 32'(rx_data), 32'h0A5);
        check("R2 done", 32'(rx_done), 1);
        check("R7 no frame error", 32'(frame_err), 0);
        // R9: read clears completion
        pulse_read();
        check("R9 read clears done", 32'(rx_done), 0);

        // R2 R3: each size with all-ones-ish pattern
        for (int nb = 5; nb <= 9; nb++) begin
            char_size = code_of(nb);
            send_frame(nb, 9'h1D7, 0, 1'b0, 1'b1, -1, 16'h0);
            check("R2 size mask", 32'(rx_data), 32'(exp_low(nb, 9'h1D7)));
            check("R3 ninth bit", 32'(rx_bit8), 32'(exp_b8(nb, 9'h1D7)));
            pulse_read();
        end
        char_size = 3'b101;  // R2: unused code behaves as 8 bits
        send_frame(8, 9'h13C, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R2 unused code", 32'(rx_data), 32'h3C);
        pulse_read();

        // R4: double speed, eight samples per bit
        char_size = 3'b011;
        dbl_speed = 1'b1;
        send_frame(8, 9'h069, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R4 double speed", 32'(rx_data), 32'h69);
        pulse_read();
        // R5 at double speed: one wrong sample at index 4
        send_frame(8, 9'h0F0, 0, 1'b0, 1'b1, 2, 16'h0010);
        check("R5 dbl single glitch", 32'(rx_data), 32'hF0);
        pulse_read();
        dbl_speed = 1'b0;

        // R5: single glitch at mid-bit ignored, two flip the bit
        send_frame(8, 9'h055, 0, 1'b0, 1'b1, 0, 16'h0100);
        check("R5 single glitch", 32'(rx_data), 32'h55);
        pulse_read();
        send_frame(8, 9'h055, 0, 1'b0, 1'b1, 0, 16'h0180);
        check("R5 double glitch", 32'(rx_data), 32'h54);
        pulse_read();

        // R6: short low pulse is not a start bit
        tick1(1'b0);
        tick1(1'b0);
        for (int i = 0; i < 200; i++) tick1(1'b1);
        check("R6 false start", 32'(rx_done), 0);

        // R7: bad stop bit flags frame error and still stores data
        send_frame(8, 9'h0C3, 0, 1'b0, 1'b0, -1, 16'h0);
        for (int i = 0; i < 20; i++) tick1(1'b1);
        check("R7 frame error", 32'(frame_err), 1);
        check("R7 data kept", 32'(rx_data), 32'hC3);
        // R8: second frame without read
        send_frame(8, 9'h03C, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R8 overrun", 32'(overrun), 1);
        check("R8 old data", 32'(rx_data), 32'hC3);
        pulse_read();
        send_frame(8, 9'h011, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R8 overrun cleared", 32'(overrun), 0);
        check("R8 new data", 32'(rx_data), 32'h11);

        // R12: interrupt gating
        for (int c = 0; c < 4; c++) begin
            rx_int_en = c[0];
            glob_int_en = c[1];
            @(negedge clk);
            check("R12 irq gate", 32'(rx_irq), 32'(c == 3));
        end
        pulse_read();
        check("R12 irq off after read", 32'(rx_irq), 0);
        rx_int_en = 1'b0;
        glob_int_en = 1'b0;

        // R10: address filtering, short size with separate marker
        mp_mode = 1'b1;
        char_size = code_of(7);
        send_frame(7, 9'h02A, 1, 1'b0, 1'b1, -1, 16'h0);
        check("R10 dropped data frame", 32'(rx_done), 0);
        check("R10 dropped keeps data", 32'(rx_data), 32'h11);
        send_frame(7, 9'h02A, 1, 1'b1, 1'b1, -1, 16'h0);
        check("R10 address frame", 32'(rx_data), 32'h2A);
        check("R10 address done", 32'(rx_done), 1);
        // dropped frame while full causes no overrun
        send_frame(7, 9'h07F, 1, 1'b0, 1'b1, -1, 16'h0);
        check("R10 no overrun on drop", 32'(overrun), 0);
        pulse_read();
        // 9-bit: ninth bit is the marker
        char_size = code_of(9);
        send_frame(9, 9'h0E1, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R10 9-bit dropped", 32'(rx_done), 0);
        send_frame(9, 9'h1E1, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R10 9-bit address", {rx_bit8, rx_data}, 32'h1E1);
        pulse_read();
        mp_mode = 1'b0;

        // R11: disable flushes register and flags
        char_size = code_of(8);
        send_frame(8, 9'h0BE, 0, 1'b0, 1'b0, -1, 16'h0);
        for (int i = 0; i < 20; i++) tick1(1'b1);
        send_frame(8, 9'h0EF, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R11 setup overrun", 32'(overrun), 1);
        rx_en = 1'b0;
        @(negedge clk);
        check("R11 flushed", {rx_data, rx_bit8, rx_done, frame_err, overrun}, 0);
        send_frame(8, 9'h0AA, 0, 1'b0, 1'b1, -1, 16'h0);
        check("R11 no receive while off", {rx_data, rx_done}, 0);
        rx_en = 1'b1;
        for (int i = 0; i < 4; i++) tick1(1'b1);

        // R2 R3 R4: random characters, sizes and speeds
        for (int k = 0; k < 40; k++) begin
            int nb;
            logic [8:0] d;
            nb = 5 + int'($urandom_range(0, 4));
            d = 9'($urandom);
            char_size = code_of(nb);
            dbl_speed = 1'($urandom_range(0, 1));
            send_frame(nb, d, 0, 1'b0, 1'b1, -1, 16'h0);
            check("R2 random data", 32'(rx_data), 32'(exp_low(nb, d)));
            check("R3 random ninth", 32'(rx_bit8), 32'(exp_b8(nb, d)));
            pulse_read();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule